// File: doc/BRIEF.md
# Execute Stage: ALU, Condition Flags and Jump Evaluation

This block is the execute step of a small 32-bit processor. From two register operands and a 4-bit function code it forms one of four results: sum, difference, bitwise AND or bitwise exclusive-or. The operand taken from the second register field (`op_b`) is both the destination value and the minuend, so a subtraction yields `op_b - op_a`. The result is combinational and appears in the same cycle as its operands.

Three condition flags (zero, sign, overflow) sit in a small register. While the write enable is high, that register captures the flags of the current operation at the next rising clock edge. A jump function code is decoded against the stored flags, never against the flags of the operation in flight, and produces a taken/not-taken decision in the same cycle.

The flag register behaves as a three-way state update with three named transitions. RESET loads zero=1, sign=0, overflow=0 when `rst` is high. UPDATE loads the new flags when the enable is high and the function code is a supported operation. HOLD keeps the stored flags in every other case.

Top module: `exec_stage`

## Requirements
- R1: Function code 0 gives `alu_res = op_b + op_a` (modulo 2^32).
- R2: Function code 1 gives `alu_res = op_b - op_a` (modulo 2^32).
- R3: Function code 2 gives `op_b & op_a`; function code 3 gives `op_b ^ op_a`.
- R4: Function codes 4 to 15 give `alu_res = 0` and leave the stored flags unchanged even when `cc_wr_en` is high.
- R5: On an update, zero is set exactly when the 32-bit result is 0, and sign copies result bit 31.
- R6: On an update, overflow is set for an add when both operands share a sign and the result's sign differs from `op_b`. For a subtract it is set when the operand signs differ and the result's sign differs from `op_b`. It is cleared for AND and XOR.
- R7: When `cc_wr_en` is low, the stored flags do not change at the clock edge.
- R8: A clock edge with `rst` high sets the stored flags to zero=1, sign=0, overflow=0.
- R9: With lt = sign xor overflow, jump code 0 is always taken. The other codes are taken as follows: 1 on lt or zero, 2 on lt, 3 on zero, 4 on not zero, 5 on not lt, 6 on neither lt nor zero.
- R10: Jump codes 7 to 15 are never taken.
- R11: `br_taken` depends only on the flags stored at the previous edges. A flag-updating operation in the current cycle affects the jump decision only from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 32 | First operand (source register value) |
| op_b | input | 32 | Second operand (destination register value) |
| alu_fn | input | 4 | Operation select |
| cc_wr_en | input | 1 | Flag capture enable |
| jmp_fn | input | 4 | Jump condition select |
| alu_res | output | 32 | Operation result |
| cc_zf | output | 1 | Stored zero flag |
| cc_sf | output | 1 | Stored sign flag |
| cc_of | output | 1 | Stored overflow flag |
| br_taken | output | 1 | Jump decision from stored flags |

## Verification
`alu_res` and `br_taken` are due in the same cycle as the inputs that produce them. The flags are due one rising edge after an enabled operation or a reset. The driver applies each stimulus at a falling edge and pushes an item holding the result and decision for that cycle, together with the flags the model holds before the coming edge. The monitor compares a quarter period after that same falling edge, so any flag change caused by a stimulus is checked in the item of the next stimulus.

// File: rtl/exec_pkg.sv
package exec_pkg;

    typedef enum logic [3:0] {
        ALU_ADD = 4'd0,
        ALU_SUB = 4'd1,
        ALU_AND = 4'd2,
        ALU_XOR = 4'd3
    } alu_fn_e;

    typedef enum logic [3:0] {
        JC_ALWAYS = 4'd0,
        JC_LE     = 4'd1,
        JC_LT     = 4'd2,
        JC_EQ     = 4'd3,
        JC_NE     = 4'd4,
        JC_GE     = 4'd5,
        JC_GT     = 4'd6
    } jmp_fn_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
    } cc_t;

    localparam cc_t CC_RESET = '{of: 1'b0, sf: 1'b0, zf: 1'b1};

    typedef enum logic [1:0] {
        CC_LOAD_RESET,
        CC_LOAD_UPDATE,
        CC_LOAD_HOLD
    } cc_action_e;

endpackage

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [3:0]        fn,
    output logic [DATA_W-1:0] res,
    output cc_t               cc_next,
    output logic              op_ok
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] diff;
    logic              ovf;

    assign sum  = op_b + op_a;
    assign diff = op_b - op_a;

    always_comb begin
        res   = '0;
        ovf   = 1'b0;
        op_ok = 1'b1;
        case (fn)
            ALU_ADD: begin
                res = sum;
                ovf = (op_a[MSB] == op_b[MSB]) && (sum[MSB] != op_b[MSB]);
            end
            ALU_SUB: begin
                res = diff;
                ovf = (op_a[MSB] != op_b[MSB]) && (diff[MSB] != op_b[MSB]);
            end
            ALU_AND: res = op_b & op_a;
            ALU_XOR: res = op_b ^ op_a;
            default: op_ok = 1'b0;
        endcase
    end

    always_comb begin
        cc_next.zf = (res == '0);
        cc_next.sf = res[MSB];
        cc_next.of = ovf;
    end

endmodule

// File: rtl/exec_ccreg.sv
module exec_ccreg
    import exec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic op_ok,
    input  cc_t  cc_in,
    output cc_t  cc_q
);
    cc_action_e action;

    always_comb begin
        if (rst)
            action = CC_LOAD_RESET;
        else if (wr_en && op_ok)
            action = CC_LOAD_UPDATE;
        else
            action = CC_LOAD_HOLD;
    end

    always_ff @(posedge clk) begin
        unique case (action)
            CC_LOAD_RESET:  cc_q <= CC_RESET;
            CC_LOAD_UPDATE: cc_q <= cc_in;
            CC_LOAD_HOLD:   cc_q <= cc_q;
            default:        cc_q <= cc_q;
        endcase
    end

    // R7
    cc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && !wr_en)) |-> $stable(cc_q));

    // R8
    cc_reset_val_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cc_q.zf && !cc_q.sf && !cc_q.of));

endmodule

// File: rtl/exec_branch.sv
module exec_branch
    import exec_pkg::*;
(
    input  logic [3:0] jfn,
    input  cc_t        cc,
    output logic       taken
);
    logic lt;

    assign lt = cc.sf ^ cc.of;

    always_comb begin
        case (jfn)
            JC_ALWAYS: taken = 1'b1;
            JC_LE:     taken = lt | cc.zf;
            JC_LT:     taken = lt;
            JC_EQ:     taken = cc.zf;
            JC_NE:     taken = ~cc.zf;
            JC_GE:     taken = ~lt;
            JC_GT:     taken = ~lt & ~cc.zf;
            default:   taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/exec_stage.sv
module exec_stage
    import exec_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [3:0]        alu_fn,
    input  logic              cc_wr_en,
    input  logic [3:0]        jmp_fn,
    output logic [DATA_W-1:0] alu_res,
    output logic              cc_zf,
    output logic              cc_sf,
    output logic              cc_of,
    output logic              br_taken
);
    cc_t  cc_next;
    cc_t  cc_q;
    logic op_ok;

    exec_alu #(.DATA_W(DATA_W)) alu_i (
        .op_a    (op_a),
        .op_b    (op_b),
        .fn      (alu_fn),
        .res     (alu_res),
        .cc_next (cc_next),
        .op_ok   (op_ok)
    );

    exec_ccreg ccreg_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cc_wr_en),
        .op_ok (op_ok),
        .cc_in (cc_next),
        .cc_q  (cc_q)
    );

    exec_branch branch_i (
        .jfn   (jmp_fn),
        .cc    (cc_q),
        .taken (br_taken)
    );

    assign cc_zf = cc_q.zf;
    assign cc_sf = cc_q.sf;
    assign cc_of = cc_q.of;

    // R4
    bad_fn_res_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_fn > 4'd3) |-> (alu_res == '0));

    // R4
    bad_fn_cc_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && alu_fn > 4'd3) |-> $stable(cc_q));

    // R6
    logic_of_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && cc_wr_en && (alu_fn == 4'd2 || alu_fn == 4'd3)) |-> !cc_of);

    // R9
    eq_follows_zf_chk: assert property (@(posedge clk) disable iff (rst)
        (jmp_fn == 4'd3) |-> (br_taken == cc_zf));

    // R10
    undef_jmp_chk: assert property (@(posedge clk) disable iff (rst)
        (jmp_fn > 4'd6) |-> !br_taken);

endmodule

// File: tb/exec_stage_tb_top.sv
module exec_stage_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  alu_fn = '0;
    logic        cc_wr_en = 1'b0;
    logic [3:0]  jmp_fn = '0;
    logic [31:0] alu_res;
    logic        cc_zf, cc_sf, cc_of, br_taken;

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_stage dut_i (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .alu_fn(alu_fn),
        .cc_wr_en(cc_wr_en), .jmp_fn(jmp_fn), .alu_res(alu_res),
        .cc_zf(cc_zf), .cc_sf(cc_sf), .cc_of(cc_of), .br_taken(br_taken)
    );

    typedef struct {
        string       tag;
        logic [31:0] res;
        logic [2:0]  cc;   // {of, sf, zf}
        logic        tk;
        bit          chk_cc;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic [2:0] mcc = 3'b000;
    bit   mcc_known = 1'b0;

    function automatic logic [31:0] m_res(logic [31:0] a, logic [31:0] b, logic [3:0] f);
        case (f)
            4'd0: return b + a;
            4'd1: return b - a;
            4'd2: return b & a;
            4'd3: return b ^ a;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic m_of(logic [31:0] a, logic [31:0] b, logic [3:0] f);
        logic [31:0] r;
        r = m_res(a, b, f);
        if (f == 4'd0) return (a[31] == b[31]) && (r[31] != b[31]);
        if (f == 4'd1) return (a[31] != b[31]) && (r[31] != b[31]);
        return 1'b0;
    endfunction

    function automatic logic m_taken(logic [3:0] j, logic [2:0] c);
        logic lt, z;
        lt = c[1] ^ c[2];
        z  = c[0];
        case (j)
            4'd0: return 1'b1;
            4'd1: return lt | z;
            4'd2: return lt;
            4'd3: return z;
            4'd4: return ~z;
            4'd5: return ~lt;
            4'd6: return ~lt & ~z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic step(input bit r, input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] f, input bit we, input logic [3:0] j,
                        input string tag);
        exp_t it;
        logic [31:0] rv;
        @(negedge clk);
        rst = r; op_a = a; op_b = b; alu_fn = f; cc_wr_en = we; jmp_fn = j;
        rv = m_res(a, b, f);
        it.tag = tag; it.res = rv; it.cc = mcc;
        it.tk = m_taken(j, mcc); it.chk_cc = mcc_known;
        q.push_back(it);
        if (r) begin
            mcc = 3'b001;
            mcc_known = 1'b1;
        end else if (we && f < 4'd4) begin
            mcc = {m_of(a, b, f), rv[31], (rv == 32'd0)};
        end
    endtask

    // monitor: compares the item of the current cycle a quarter period after the driving edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                exp_t it;
                bit bad;
                it = q.pop_front();
                n_tests++;
                bad = (alu_res !== it.res);
                if (it.chk_cc)
                    bad = bad || ({cc_of, cc_sf, cc_zf} !== it.cc) || (br_taken !== it.tk);
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: res=%h cc(of,sf,zf)=%b taken=%b expected res=%h cc=%b taken=%b",
                             it.tag, alu_res, {cc_of, cc_sf, cc_zf}, br_taken,
                             it.res, it.cc, it.tk);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(1, 0, 0, 4'd0, 0, 4'd0, "R8");
        step(0, 1, 2, 4'd0, 0, 4'd3, "R8");                         // reset flags, EQ taken
        step(0, 32'h7fffffff, 32'h1, 4'd0, 1, 4'd0, "R1");          // add overflow
        step(0, 5, 7, 4'd1, 1, 4'd2, "R6");                         // of=1 sf=1 visible
        step(0, 7, 5, 4'd1, 1, 4'd6, "R2");                         // 5-7
        step(0, 1, 32'h80000000, 4'd1, 1, 4'd2, "R9");              // sub overflow
        step(0, 32'hF0F0F0F0, 32'hFF00FF00, 4'd2, 1, 4'd5, "R6");
        step(0, 32'h0F0F0F0F, 32'hFF00FF00, 4'd3, 1, 4'd1, "R3");
        step(0, 32'h1234, 32'h1234, 4'd3, 0, 4'd4, "R7");           // zero result, no write
        step(0, 0, 0, 4'd0, 0, 4'd3, "R7");
        step(0, 5, 5, 4'd1, 1, 4'd3, "R11");                        // same-cycle zero not seen
        step(0, 0, 0, 4'd0, 0, 4'd3, "R5");
        step(0, 9, 3, 4'd5, 1, 4'd4, "R4");
        step(0, 9, 3, 4'hF, 1, 4'd3, "R4");
        for (int j = 0; j < 16; j++)
            step(0, 0, 0, 4'd0, 0, 4'(j), (j > 6) ? "R10" : "R9");
        step(0, 3, 1, 4'd1, 1, 4'd0, "R2");                         // -2: sf=1
        for (int j = 0; j < 16; j++)
            step(0, 0, 0, 4'd0, 0, 4'(j), (j > 6) ? "R10" : "R9");
        step(0, 32'h40000000, 32'h40000000, 4'd0, 1, 4'd0, "R6");   // of=1 sf=1
        for (int j = 0; j < 16; j++)
            step(0, 0, 0, 4'd0, 0, 4'(j), (j > 6) ? "R10" : "R9");
        step(0, 32'h80000000, 32'h80000000, 4'd0, 1, 4'd0, "R6");   // of=1 zf=1
        for (int j = 0; j < 7; j++)
            step(0, 0, 0, 4'd0, 0, 4'(j), "R9");
        step(1, 2, 3, 4'd1, 1, 4'd4, "R8");
        step(0, 0, 0, 4'd0, 0, 4'd3, "R8");
        step(0, 32'hFFFFFFFF, 32'h1, 4'd0, 1, 4'd0, "R5");          // add to zero
        step(0, 0, 0, 4'd2, 0, 4'd3, "R5");
        @(negedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule